// File: doc/BRIEF.md
# Multi-Mode Timer/Counter Core

This block is a 16-bit timer/counter. A prescaler divides its timebase by a power of two chosen by a clock-select field. A mode field chooses how the count moves and where it turns around. That turnaround value (the top) is one of three things:
- the all-ones value for the mode's width,
- compare register A,
- a separate capture/top register.

The block has four counting styles:
- free-running normal counting,
- clear-on-compare counting,
- fast PWM counting, which runs up and wraps,
- phase-correct PWM counting, which runs up to the top and back down to zero.

A single register write port loads the control word, three compare registers and the capture/top register. The block drives the current count, a one-cycle overflow pulse and one match pulse per compare channel. The waveform pins, capture edge logic and interrupt handling that would consume these pulses sit outside the block.

A control write restarts the count only when the clock-select, mode or timebase-select field actually changes value. Writes that touch only the other control bits leave the count running. The timebase is either every system clock cycle or, when the async select bit is set, a strobe input. That strobe marks each edge of a slow external reference (32768 Hz), already brought into the system clock domain.

Top module: `wave_timer`

## Requirements
- R1: After reset `count_o` is 0, `ovf_o` and `match_o` are 0, every register is 0, and the counter is stopped.
- R2: A clock-select value of 0 stops the counter. Writing it from a non-zero value clears the count and drops any pending pulse, and the count then stays at 0.
- R3: The clock-select field sets the prescaler division, and the count advances once per division period. Clock selects 1 to 7 divide by 1, 8, 64, 256, 1024, 4096 and 16384 respectively. The first advance after a restart comes a full division period later.
- R4: Modes 0 (normal) and 3 (fast PWM, full width) count up to 16'hFFFF. Mode 2 (fast PWM, 8-bit) counts up to 16'h00FF. On the tick after the count reaches the top, the count becomes 0 and `ovf_o` pulses high in that same cycle.
- R5: In mode 1 (clear-on-compare) the top is compare register A, so the period is A+1 ticks. The overflow pulse comes with the wrap to 0.
- R6: Mode 4 (phase-correct, top = A) and mode 5 (phase-correct, top = capture register) count up to the top and then down. `ovf_o` pulses when the count reaches 0 on the way down. For a top of T, the sequence from restart is 1..T, T-1..0.
- R7: `match_o[i]` pulses high for one cycle when a tick moves the count to a value equal to compare register i. Bit 0 is channel A, bit 1 is B and bit 2 is C.
- R8: A control write restarts the counter only when control bits [6:0] differ from the stored value. A restart sets the count to 0, the direction to up and the prescaler phase to 0. A write with equal bits [6:0] and any value in bits [15:7] does not disturb counting.
- R9: With the async select bit (control bit 6) set, the prescaler advances only in cycles where `async_tick_i` is high. With the bit clear, it advances every clock cycle.
- R10: Modes 6 and 7 are unsupported, and the counter stays stopped at 0 while either is selected.
- R11: The register addresses are 0 for control, 1, 2 and 3 for compare A, B and C, and 4 for the capture/top register. Control bits [2:0] are clock select, [5:3] are mode and [6] is async select. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| async_tick_i | input | 1 | One-cycle strobe per edge of the slow reference timebase |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | Overflow / bottom pulse |
| match_o | output | 3 | Compare match pulses, bit 0 = A, bit 1 = B, bit 2 = C |

## Verification
The assertions check several properties on every cycle:
- an overflow pulse always comes with a zero count;
- a restart clears the count and the pulses;
- the count never moves without a prescaler tick;
- a channel-A match always agrees with the previous value of register A;
- with the async timebase selected, the count holds whenever the strobe is low.

Some behaviour only the bench's scenarios can show. These are the exact division ratios, the per-mode top values and the up/down sequence of phase-correct counting. They also include the difference between a control write that restarts the count and one that does not.

// File: rtl/wave_timer_pkg.sv
package wave_timer_pkg;
  localparam int CS_W   = 3;
  localparam int MODE_W = 3;
  localparam int ADDR_W = 3;
  localparam int SH_W   = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_CMP0 = 3'd1
  } reg_addr_e;

  typedef enum logic [MODE_W-1:0] {
    M_NORM   = 3'd0,
    M_CTC    = 3'd1,
    M_FAST8  = 3'd2,
    M_FAST   = 3'd3,
    M_PC_A   = 3'd4,
    M_PC_CAP = 3'd5,
    M_RSV6   = 3'd6,
    M_RSV7   = 3'd7
  } mode_e;

  typedef struct packed {
    logic             async_sel;
    mode_e            mode;
    logic [CS_W-1:0]  cs;
  } ctrl_t;

  // prescaler shift per clock select; 0 means stopped
  function automatic logic [SH_W-1:0] cs_shift(logic [CS_W-1:0] cs);
    case (cs)
      3'd1:    return 4'd0;
      3'd2:    return 4'd3;
      3'd3:    return 4'd6;
      3'd4:    return 4'd8;
      3'd5:    return 4'd10;
      3'd6:    return 4'd12;
      3'd7:    return 4'd14;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic mode_ok(mode_e m);
    return !(m inside {M_RSV6, M_RSV7});
  endfunction
endpackage

// File: rtl/wave_timer_regs.sv
module wave_timer_regs
  import wave_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCMP  = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [CNT_W-1:0]           wr_data_i,
  output ctrl_t                      ctrl_o,
  output logic [NCMP-1:0][CNT_W-1:0] cmp_o,
  output logic [CNT_W-1:0]           capt_o,
  output logic                       restart_o
);
  localparam int CTRL_W    = $bits(ctrl_t);
  localparam int CAPT_ADDR = int'(A_CMP0) + NCMP;

  ctrl_t ctrl_q;
  ctrl_t ctrl_wr;
  logic  ctrl_sel;

  assign ctrl_wr   = ctrl_t'(wr_data_i[CTRL_W-1:0]);
  assign ctrl_sel  = wr_en_i && (wr_addr_i == A_CTRL);
  // only the clock, mode and async fields count as a reconfiguration
  assign restart_o = ctrl_sel && (ctrl_wr != ctrl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (ctrl_sel) ctrl_q <= ctrl_wr;
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cmp_o[i] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(int'(A_CMP0) + i)) cmp_o[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) capt_o <= '0;
    else if (wr_en_i && wr_addr_i == ADDR_W'(CAPT_ADDR)) capt_o <= wr_data_i;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/wave_timer_presc.sv
module wave_timer_presc
  import wave_timer_pkg::*;
#(
  parameter int PRE_W = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            restart_i,
  input  logic            base_i,
  input  logic [SH_W-1:0] shift_i,
  output logic            tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim    = PRE_W'((32'd1 << shift_i) - 32'd1);
  assign tick_o = run_i && base_i && (pre_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pre_q <= '0;
    else if (restart_i || !run_i) pre_q <= '0;
    else if (base_i)             pre_q <= tick_o ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/wave_timer_cnt.sv
module wave_timer_cnt
  import wave_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCMP  = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       restart_i,
  input  logic                       tick_i,
  input  mode_e                      mode_i,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0]           capt_i,
  output logic [CNT_W-1:0]           count_o,
  output logic                       ovf_o,
  output logic [NCMP-1:0]            match_o
);
  localparam logic [CNT_W-1:0] TOP8 = CNT_W'(8'hFF);

  logic [CNT_W-1:0] cnt_q, cnt_nx, top;
  logic             up_q, up_nx, wrap;
  logic             ovf_q;
  logic [NCMP-1:0]  match_q, match_d;
  logic             pc;

  always_comb begin
    case (mode_i)
      M_FAST8:          top = TOP8;
      M_CTC, M_PC_A:    top = cmp_i[0];
      M_PC_CAP:         top = capt_i;
      default:          top = '1;
    endcase
  end

  assign pc = (mode_i == M_PC_A) || (mode_i == M_PC_CAP);

  always_comb begin
    cnt_nx = cnt_q;
    up_nx  = up_q;
    wrap   = 1'b0;
    if (tick_i) begin
      if (!pc) begin
        up_nx = 1'b1;
        if (cnt_q >= top) begin
          cnt_nx = '0;
          wrap   = 1'b1;
        end else begin
          cnt_nx = cnt_q + 1'b1;
        end
      end else if (up_q) begin
        if (cnt_q >= top) begin
          if (cnt_q == '0) begin
            wrap = 1'b1;
          end else begin
            cnt_nx = cnt_q - 1'b1;
            up_nx  = 1'b0;
          end
        end else begin
          cnt_nx = cnt_q + 1'b1;
        end
      end else begin
        cnt_nx = cnt_q - 1'b1;
        if (cnt_nx == '0) begin
          wrap  = 1'b1;
          up_nx = 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_match
    assign match_d[i] = tick_i && (cnt_nx == cmp_i[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      up_q    <= 1'b1;
      ovf_q   <= 1'b0;
      match_q <= '0;
    end else if (restart_i) begin
      cnt_q   <= '0;
      up_q    <= 1'b1;
      ovf_q   <= 1'b0;
      match_q <= '0;
    end else begin
      cnt_q   <= cnt_nx;
      up_q    <= up_nx;
      ovf_q   <= wrap;
      match_q <= match_d;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
  assign match_o = match_q;

  AST_OVF_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> cnt_q == '0); // R4
  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0) && !ovf_q && (match_q == '0)); // R8
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> cnt_q == $past(cnt_q)); // R2
  AST_MATCH_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q[0] |-> cnt_q == $past(cmp_i[0])); // R7
endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wave_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCMP  = 3,
  parameter int PRE_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              async_tick_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o,
  output logic [NCMP-1:0]   match_o
);
  ctrl_t                      ctrl;
  logic [NCMP-1:0][CNT_W-1:0] cmp;
  logic [CNT_W-1:0]           capt;
  logic                       restart, run, base, tick;

  wave_timer_regs #(.CNT_W(CNT_W), .NCMP(NCMP)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl), .cmp_o(cmp), .capt_o(capt), .restart_o(restart)
  );

  assign run  = (ctrl.cs != '0) && mode_ok(ctrl.mode);
  assign base = ctrl.async_sel ? async_tick_i : 1'b1;

  wave_timer_presc #(.PRE_W(PRE_W)) u_presc (
    .clk_i, .rst_ni, .run_i(run), .restart_i(restart), .base_i(base),
    .shift_i(cs_shift(ctrl.cs)), .tick_o(tick)
  );

  wave_timer_cnt #(.CNT_W(CNT_W), .NCMP(NCMP)) u_cnt (
    .clk_i, .rst_ni, .restart_i(restart), .tick_i(tick), .mode_i(ctrl.mode),
    .cmp_i(cmp), .capt_i(capt), .count_o, .ovf_o, .match_o
  );

  AST_ASYNC_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.async_sel && !async_tick_i && !restart) |=> $stable(count_o)); // R9
endmodule

// File: tb/wave_timer_bench.sv
module wave_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        async_tick = 1'b0;
  logic [15:0] count;
  logic        ovf;
  logic [2:0]  match;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  wave_timer u_wave_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .async_tick_i(async_tick),
    .count_o(count), .ovf_o(ovf), .match_o(match)
  );

  // reference model built from the requirements
  logic [6:0]  m_ctl;
  logic [15:0] m_cmp [3];
  logic [15:0] m_cap, m_cnt, m_top, n;
  logic        m_up, m_ovf, nu, w, tk, run, base, pcm, rs;
  logic [2:0]  m_match, mm;
  logic [31:0] m_pre, lim;

  function automatic int div_shift(logic [2:0] cs);
    int t [8] = '{0, 0, 3, 6, 8, 10, 12, 14};
    return t[cs];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = '0; m_cap = '0; m_cnt = '0; m_up = 1; m_ovf = 0; m_match = '0; m_pre = 0;
      for (int i = 0; i < 3; i++) m_cmp[i] = '0;
    end else begin
      run  = (m_ctl[2:0] != 0) && (m_ctl[5:3] < 6);
      base = m_ctl[6] ? async_tick : 1'b1;
      lim  = (32'd1 << div_shift(m_ctl[2:0])) - 1;
      tk   = run && base && (m_pre == lim);
      case (m_ctl[5:3])
        3'd2:       m_top = 16'h00FF;
        3'd1, 3'd4: m_top = m_cmp[0];
        3'd5:       m_top = m_cap;
        default:    m_top = 16'hFFFF;
      endcase
      pcm = (m_ctl[5:3] == 4) || (m_ctl[5:3] == 5);
      n = m_cnt; nu = m_up; w = 0;
      if (tk) begin
        if (!pcm) begin
          if (m_cnt >= m_top) begin n = 0; w = 1; end else n = m_cnt + 1;
        end else if (m_up) begin
          if (m_cnt >= m_top) begin
            if (m_cnt == 0) w = 1; else begin n = m_cnt - 1; nu = 0; end
          end else n = m_cnt + 1;
        end else begin
          n = m_cnt - 1;
          if (n == 0) begin w = 1; nu = 1; end
        end
      end
      for (int i = 0; i < 3; i++) mm[i] = tk && (n == m_cmp[i]);
      rs = wr_en && (wr_addr == 0) && (wr_data[6:0] != m_ctl);
      if (rs) begin
        m_cnt = 0; m_up = 1; m_ovf = 0; m_match = 0; m_pre = 0;
      end else begin
        m_cnt = n; m_up = nu; m_ovf = w; m_match = mm;
        if (!run) m_pre = 0;
        else if (base) m_pre = tk ? 0 : m_pre + 1;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_ctl = wr_data[6:0];
          3'd1: m_cmp[0] = wr_data;
          3'd2: m_cmp[1] = wr_data;
          3'd3: m_cmp[2] = wr_data;
          3'd4: m_cap = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_n(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 count", count, 0); chk("R1 ovf", ovf, 0); chk("R1 match", match, 0);
    wait_n(5);
    chk("R1 stopped", count, 0);

    // R3: cs=2 divides by 8
    wr(0, 16'h0002);
    wait_n(23); chk("R3 count@23", count, 2);
    wait_n(1);  chk("R3 count@24", count, 3);

    // R4: fast 8-bit top 0xFF
    wr(0, 16'h0011);
    wait_n(255); chk("R4 count@255", count, 16'hFF); chk("R4 no ovf", ovf, 0);
    wait_n(1);   chk("R4 wrap", count, 0); chk("R4 ovf", ovf, 1);

    // R5/R7: clear on compare A=5
    wr(1, 16'd5);
    wr(0, 16'h0009);
    wait_n(5); chk("R5 count@5", count, 5); chk("R7 match A", match, 3'b001);
    wait_n(1); chk("R5 wrap", count, 0); chk("R5 ovf", ovf, 1);

    // R6: phase correct, top from capture = 3
    wr(4, 16'd3);
    wr(0, 16'h0029);
    wait_n(3); chk("R6 at top", count, 3);
    wait_n(1); chk("R6 down", count, 2);
    wait_n(2); chk("R6 bottom", count, 0); chk("R6 ovf", ovf, 1);
    wait_n(1); chk("R6 up again", count, 1);

    // R8: spare bits do not restart, field change does
    wr(1, 16'd200);
    wr(0, 16'h0009);
    wait_n(10); chk("R8 running", count, 10);
    wr(0, 16'h0409);
    chk("R8 spare write no restart", count, 11);
    wr(0, 16'h000A);
    chk("R8 restart on cs change", count, 0);

    // R2: cs=0 stops and clears
    wait_n(16);
    wr(0, 16'h0008);
    chk("R2 cleared", count, 0);
    wait_n(20); chk("R2 stays", count, 0); chk("R2 no ovf", ovf, 0);

    // R9: async timebase
    wr(0, 16'h0041);
    wait_n(10); chk("R9 no strobe", count, 0);
    for (int i = 0; i < 3; i++) begin
      async_tick = 1; @(negedge clk); async_tick = 0; @(negedge clk);
    end
    chk("R9 three strobes", count, 3);

    // R10: unsupported mode
    wr(0, 16'h0031);
    wait_n(10); chk("R10 stopped", count, 0);

    // R7/R11: channels B and C; address 6 ignored
    wr(2, 16'd3);
    wr(3, 16'd7);
    wr(6, 16'd4);
    wr(0, 16'h0001);
    wait_n(3); chk("R7 match B", match, 3'b010);
    wait_n(4); chk("R7 match C", match, 3'b100);
    wait_n(1); chk("R11 addr6 no effect", match, 3'b000);

    // random phase against the model
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      chk("R4 R6 count model", count, m_cnt);
      chk("R6 ovf model", ovf, m_ovf);
      chk("R7 match model", match, m_match);
      async_tick = ($urandom % 3) == 0;
      if (($urandom % 40) == 0) begin
        logic [2:0] a = 3'($urandom % 6);
        logic [15:0] d;
        if (a == 0) begin
          d = {9'($urandom), 1'(($urandom % 8) == 0), 3'($urandom),
               (($urandom % 4) != 0) ? 3'd1 : 3'($urandom)};
        end else d = 16'($urandom % 300);
        wr_en = 1; wr_addr = a; wr_data = d;
      end else wr_en = 0;
    end
    @(negedge clk);
    finish_run();
  end
endmodule